// File: doc/BRIEF.md
# I2C Address-Phase Extension-Code Detector

This block monitors an I2C bus through synchronous samples of SCL and SDA. After every START it shifts in the first byte, most significant bit first. At the falling edge of the eighth SCL clock it compares the upper seven bits with a stored local slave address. In the same cycle it checks whether the byte belongs to one of the reserved extension-code groups, and if so it reports which kind. The two flags, the code type and a one-cycle interrupt reach software through a single status byte. Software then decides how to continue.

Software may ask the block to release the bus after the interrupt. From then on the block ignores all SCL and SDA activity until the next START. A separate read-back checker takes a byte the device is about to drive and captures what actually appears on SDA over the next eight SCL clocks. It reports a transmit error when the two bytes differ.

Every pin is a plain control or status signal. No data stream crosses the block boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_xcode_detector`

## Requirements
- R1: Status bit 5 (extension flag) is set at the address interrupt when the received byte's upper four bits are 0000 or 1111, and is 0 otherwise.
- R2: `irq_o` is a single-cycle pulse raised after the falling edge of the eighth SCL clock of the address byte, and never for the ninth (acknowledge) clock.
- R3: The local address register changes only through `own_we`; receiving any address byte, including an extension code, leaves `own_addr_o` unchanged.
- R4: Status bit 4 (match flag) is set when received bits 7..1 equal the local address. With a local address of 11110XX and a received 11110XX plus R/W=0, bits 5 and 4 are both set.
- R5: Status bits 2..0 hold the code type: 0 not an extension code, 1 general call (0000000, R/W=0), 2 start byte (0000000, R/W=1), 3 CBUS address (0000001), 4 other-bus-format reserve (0000010), 5 ten-bit address lead (11110XX), 6 any other byte in the 0000 or 1111 groups. Bits 7, 6 and 3 read 0.
- R6: After `tx_start`, the eight SDA levels sampled on the next eight SCL rising edges are compared with `tx_byte`. `tx_done_o` pulses once, and `tx_err_o` is 1 exactly when the two differ.
- R7: A `release_req` pulse puts the block in standby. Later SCL clocks produce no interrupt and no flag change until a new START.
- R8: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A repeated START in mid-byte restarts the bit count, so only the following eight bits form the address.
- R9: Status bits 5, 4 and 2..0 are cleared by every START.
- R10: SDA is sampled on SCL rising edges, most significant bit first, and the eighth bit is the R/W bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronous SCL sample |
| sda_i | input | 1 | Synchronous SDA sample |
| own_we | input | 1 | Write strobe for the local address |
| own_wdata | input | 7 | New local address |
| own_addr_o | output | 7 | Stored local address |
| release_req | input | 1 | Enter standby until the next START |
| tx_start | input | 1 | Load a reference byte and begin read-back capture |
| tx_byte | input | 8 | Byte being driven onto SDA |
| irq_o | output | 1 | Address-phase interrupt pulse |
| status_o | output | 8 | {00, extension, match, 0, code type[2:0]} |
| tx_done_o | output | 1 | Read-back capture finished (pulse) |
| tx_err_o | output | 1 | Captured byte differs from reference |

## Verification
The address phase is driven with a plain matching address and with one byte from each extension class: general call, start byte, CBUS, other-format reserve, an unassigned byte in the 0000 group, a ten-bit lead matching the local address, and a 11111 byte. Together these separate the nibble test from the seven-bit compare and expose any swap of class encodings or of the R/W bit. A repeated START after four stray bits shows whether the counter restarts. A release in mid-byte followed by more clocks shows whether standby really suppresses the interrupt. The read-back check is run once with an identical byte and once with a single flipped bit.

// File: rtl/i2c_xd_pkg.sv
package i2c_xd_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int XT_W   = 3;

  typedef enum logic [XT_W-1:0] {
    XC_NONE   = 3'd0,
    XC_GCALL  = 3'd1,
    XC_STARTB = 3'd2,
    XC_CBUS   = 3'd3,
    XC_RSVFMT = 3'd4,
    XC_TENBIT = 3'd5,
    XC_OTHER  = 3'd6
  } xcode_e;

  function automatic logic is_xcode(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: 4] == 4'h0) || (b[BYTE_W-1 -: 4] == 4'hF);
  endfunction

  function automatic xcode_e classify(input logic [BYTE_W-1:0] b);
    xcode_e t;
    t = XC_NONE;
    if (b[BYTE_W-1 -: 4] == 4'h0) begin
      case (b[BYTE_W-1:1])
        7'd0:    t = b[0] ? XC_STARTB : XC_GCALL;
        7'd1:    t = XC_CBUS;
        7'd2:    t = XC_RSVFMT;
        default: t = XC_OTHER;
      endcase
    end else if (b[BYTE_W-1 -: 4] == 4'hF) begin
      t = (b[BYTE_W-1 -: 5] == 5'b11110) ? XC_TENBIT : XC_OTHER;
    end
    return t;
  endfunction
endpackage

// File: rtl/i2c_xd_edges.sv
module i2c_xd_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // SCL held high across both samples qualifies an SDA edge as a bus condition.
  always_comb begin
    scl_rise  = scl_i & ~scl_q;
    scl_fall  = ~scl_i & scl_q;
    start_evt = scl_i & scl_q & sda_q & ~sda_i;
    stop_evt  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/i2c_xd_addr_phase.sv
module i2c_xd_addr_phase
  import i2c_xd_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_i,
  input  logic          release_req,
  input  logic [AW-1:0] own_addr,
  output logic          irq,
  output logic          ext_flag,
  output logic          match_flag,
  output xcode_e        xtype
);
  localparam int BW    = AW + 1;
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW);

  logic             active;
  logic [CNT_W-1:0] bit_cnt;
  logic [BW-1:0]    shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      bit_cnt    <= '0;
      shreg      <= '0;
      irq        <= 1'b0;
      ext_flag   <= 1'b0;
      match_flag <= 1'b0;
      xtype      <= XC_NONE;
    end else begin
      irq <= 1'b0;
      if (start_evt) begin
        // Any START, repeated or not, opens a fresh address phase.
        active     <= 1'b1;
        bit_cnt    <= '0;
        ext_flag   <= 1'b0;
        match_flag <= 1'b0;
        xtype      <= XC_NONE;
      end else if (release_req || stop_evt) begin
        active <= 1'b0;
      end else if (active) begin
        if (scl_rise && bit_cnt < LAST) begin
          shreg   <= {shreg[BW-2:0], sda_i};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && bit_cnt == LAST) begin
          irq        <= 1'b1;
          ext_flag   <= is_xcode(shreg);
          match_flag <= (shreg[BW-1:1] == own_addr);
          xtype      <= classify(shreg);
          active     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_xd_tx_readback.sv
module i2c_xd_tx_readback #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [BW-1:0] tx_byte,
  input  logic          scl_rise,
  input  logic          sda_i,
  output logic          tx_done,
  output logic          tx_err
);
  localparam int CNT_W = $clog2(BW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [BW-1:0]    ref_q, cap_q;
  logic [BW-1:0]    cap_next;

  assign cap_next = {cap_q[BW-2:0], sda_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      ref_q   <= '0;
      cap_q   <= '0;
      tx_done <= 1'b0;
      tx_err  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (tx_start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        ref_q  <= tx_byte;
        tx_err <= 1'b0;
      end else if (busy && scl_rise) begin
        cap_q <= cap_next;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy    <= 1'b0;
          tx_done <= 1'b1;
          tx_err  <= (cap_next != ref_q);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_xcode_detector.sv
module i2c_xcode_detector
  import i2c_xd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              own_we,
  input  logic [ADDR_W-1:0] own_wdata,
  output logic [ADDR_W-1:0] own_addr_o,
  input  logic              release_req,
  input  logic              tx_start,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              irq_o,
  output logic [7:0]        status_o,
  output logic              tx_done_o,
  output logic              tx_err_o
);
  logic   scl_rise, scl_fall, start_evt, stop_evt;
  logic   ext_flag, match_flag;
  xcode_e xtype;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_addr_o <= '0;
    else if (own_we) own_addr_o <= own_wdata;
  end

  i2c_xd_edges u_edges (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_xd_addr_phase #(.AW(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_i(sda_i),
    .release_req(release_req), .own_addr(own_addr_o),
    .irq(irq_o), .ext_flag(ext_flag), .match_flag(match_flag), .xtype(xtype)
  );

  i2c_xd_tx_readback #(.BW(BYTE_W)) u_txchk (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_byte(tx_byte),
    .scl_rise(scl_rise), .sda_i(sda_i),
    .tx_done(tx_done_o), .tx_err(tx_err_o)
  );

  assign status_o = {2'b00, ext_flag, match_flag, 1'b0, xtype};
endmodule

// File: rtl/i2c_xd_checker.sv
module i2c_xd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic       tx_done_o,
  input logic       own_we,
  input logic       start_evt,
  input logic [7:0] status_o,
  input logic [6:0] own_addr_o
);
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !own_we |=> $stable(own_addr_o));

  p_type_implies_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2:0] != 3'd0) |-> status_o[5]);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |=> !tx_done_o);

  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (status_o[5:4] == 2'b00 && status_o[2:0] == 3'd0));
endmodule

bind i2c_xcode_detector i2c_xd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .tx_done_o(tx_done_o),
  .own_we(own_we), .start_evt(start_evt), .status_o(status_o),
  .own_addr_o(own_addr_o)
);

// File: tb/i2c_xcode_detector_test.sv
`timescale 1ns/1ps
module i2c_xcode_detector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1, sda = 1'b1;
  logic       own_we = 1'b0;
  logic [6:0] own_wdata = '0;
  logic [6:0] own_addr_o;
  logic       release_req = 1'b0;
  logic       tx_start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       irq_o, tx_done_o, tx_err_o;
  logic [7:0] status_o;

  int checks = 0, errors = 0, irq_seen = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  logic       err_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  i2c_xcode_detector uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .own_we(own_we), .own_wdata(own_wdata), .own_addr_o(own_addr_o),
    .release_req(release_req), .tx_start(tx_start), .tx_byte(tx_byte),
    .irq_o(irq_o), .status_o(status_o), .tx_done_o(tx_done_o), .tx_err_o(tx_err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected status from the requirement text (R1, R4, R5).
  function automatic logic [7:0] exp_status(input logic [7:0] b, input logic [6:0] own);
    logic ext, m; logic [2:0] t;
    ext = (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
    m   = (b[7:1] == own);
    t   = 3'd0;
    if (b[7:4] == 4'h0) begin
      if (b[7:1] == 7'd0)      t = b[0] ? 3'd2 : 3'd1;
      else if (b[7:1] == 7'd1) t = 3'd3;
      else if (b[7:1] == 7'd2) t = 3'd4;
      else                     t = 3'd6;
    end else if (b[7:4] == 4'hF) begin
      t = (b[7:3] == 5'b11110) ? 3'd5 : 3'd6;
    end
    return {2'b00, ext, m, 1'b0, t};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b);
    sda = b; wclk(3);
    scl = 1'b1; wclk(3);
    scl = 1'b0; wclk(3);
  endtask

  task automatic bus_start();
    sda = 1'b1; wclk(2);
    scl = 1'b1; wclk(3);
    sda = 1'b0; wclk(3);
    scl = 1'b0; wclk(3);
  endtask

  task automatic bus_stop();
    sda = 1'b0; wclk(2);
    scl = 1'b1; wclk(3);
    sda = 1'b1; wclk(3);
  endtask

  // Driver: queue the expected status, then clock the byte out MSB first (R10) plus an ACK slot.
  task automatic send_addr(input logic [7:0] b, input string tag);
    exp_q.push_back(exp_status(b, own_addr_o));
    tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(1'b0);
  endtask

  task automatic send_tx(input logic [7:0] b, input logic [7:0] flip);
    @(negedge clk); tx_byte = b; tx_start = 1'b1;
    @(negedge clk); tx_start = 1'b0;
    err_q.push_back(flip != 8'h00);
    for (int i = 7; i >= 0; i--) bus_bit(b[i] ^ flip[i]);
  endtask

  task automatic set_own(input logic [6:0] a);
    @(negedge clk); own_we = 1'b1; own_wdata = a;
    @(negedge clk); own_we = 1'b0;
  endtask

  // Monitor: compare each interrupt and each read-back result against the queues.
  always @(negedge clk) begin
    if (rst_n && irq_o) begin
      irq_seen++;
      if (exp_q.size() == 0) check(1'b0, "R2/R7 unexpected irq", status_o, 0);
      else begin
        logic [7:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check(status_o == e, t, status_o, e);
      end
    end
    if (rst_n && tx_done_o) begin
      if (err_q.size() == 0) check(1'b0, "R6 unexpected done", 1, 0);
      else begin
        logic e;
        e = err_q.pop_front();
        check(tx_err_o == e, "R6 readback", tx_err_o, e);
      end
    end
  end

  initial begin
    wclk(100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    wclk(4); rst_n = 1'b1; wclk(2);
    check(status_o == 8'h00 && !irq_o && !tx_err_o, "reset", status_o, 0);

    set_own(7'h50);
    bus_start(); send_addr(8'hA0, "R4 R10 plain match");
    bus_start(); send_addr(8'h00, "R1 R5 general call");
    bus_start();
    check(status_o == 8'h00, "R9 START clears", status_o, 0);
    send_addr(8'h01, "R5 start byte");
    bus_start(); send_addr(8'h02, "R5 CBUS");
    bus_start(); send_addr(8'h05, "R5 other-format reserve");
    bus_start(); send_addr(8'h07, "R5 other in 0000 group");
    bus_start(); send_addr(8'h82, "R1 R4 no match no ext");
    bus_stop();

    set_own(7'h79);
    bus_start(); send_addr(8'hF2, "R4 ten-bit both flags");
    check(own_addr_o == 7'h79, "R3 address kept", own_addr_o, 7'h79);
    bus_start(); send_addr(8'hF8, "R5 1111 other");
    check(own_addr_o == 7'h79, "R3 address kept 2", own_addr_o, 7'h79);

    // R8 repeated START mid-byte restarts the count
    set_own(7'h50);
    n = irq_seen;
    bus_start();
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    bus_start(); send_addr(8'hA0, "R8 repeated start");
    check(irq_seen == n + 1, "R8 one irq", irq_seen, n + 1);

    // R7 release mid-byte: no irq, flags unchanged
    n = irq_seen;
    bus_start();
    for (int i = 0; i < 3; i++) bus_bit(1'b0);
    @(negedge clk); release_req = 1'b1; @(negedge clk); release_req = 1'b0;
    for (int i = 0; i < 7; i++) bus_bit(1'b0);
    check(irq_seen == n, "R7 release no irq", irq_seen, n);
    check(status_o == 8'h00, "R7 flags untouched", status_o, 0);
    bus_start(); send_addr(8'hA1, "R7 resumes after START");

    // R6 transmit read-back
    send_tx(8'hC5, 8'h00);
    send_tx(8'h3A, 8'h10);
    wclk(5);
    check(exp_q.size() == 0 && err_q.size() == 0, "R2 R6 all results seen",
          exp_q.size() + err_q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule